// File: doc/BRIEF.md
# Serial Pseudo-Random Pattern Lock and Error Monitor

This block watches a serial bit stream that arrives one bit per clock, qualified by a valid strobe. It finds and locks onto a pseudo-random sequence whose linear feedback polynomial is set by a tap mask and an order input. While searching, it fills a local shift register directly from the first n received bits. It then lets that register run freely and compares each prediction with the next incoming bit. Lock is declared only after fifty predictions in a row have matched. A single mismatch throws away the work done so far and starts the search again.

Once locked, the local generator no longer takes in received data. Each received bit is compared against the generated bit, and every difference produces a one-cycle error pulse. A 64-bit sliding history of these error flags carries a running error total. When the total reaches six, lock is dropped, a sticky loss-of-sync flag is raised, the history is emptied and the search begins again. A hold input keeps the block in search so that the polynomial can be changed safely.

Top module: `prbs_lock_top`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the block enters search with an empty error history. After that edge `locked`, `bit_err` and `los_flag` all read 0.
- R2: In search, the first n valid bits (n = `poly_order`) load the local register. Each of the next 50 valid bits is compared with the prediction. If all 50 match, `locked` reads 1 in the cycle after the edge that took the (n+50)th valid bit, and not before.
- R3: A mismatch on any qualification bit discards that bit and restarts the search. Counting begins again from the next valid bit, so lock needs a further n+50 clean bits.
- R4: While locked, each valid bit that differs from the generated bit causes `bit_err` to read 1 for exactly the following cycle. A matching bit gives 0. `bit_err` is never raised for bits taken in search.
- R5: While locked, the error window covers the current valid bit and the 63 valid bits before it. A valid errored bit that brings the window total to 6 clears `locked` after that same edge, and `bit_err` reads 1 in the same cycle. Six errors spanning 64 positions cause loss. Six errors spanning 65 positions do not.
- R6: `los_flag` is set by every loss of sync and stays set through a later relock. It is cleared by a cycle with `los_clear` = 1. If a loss and `los_clear` fall in the same cycle, the set wins.
- R7: `hold_search` = 1 forces search after the next edge, restarts the search count and empties the error history. It leaves `los_flag` unchanged. The polynomial may be changed while it is held, and the block locks to the new polynomial after release.
- R8: A cycle with `in_valid` = 0 changes nothing: no lock progress, no error pulse and no window update, whatever the value of `in_bit`.
- R9: Bit i of `poly_taps` selects the bit received i+1 valid bits earlier. The predicted bit is the XOR of the selected bits, and only bits below `poly_order` take part. Orders from 7 to 31 are supported, for example mask 0x60 with order 7, mask 0x6000 with order 15 and mask 0x48000000 with order 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_bit` for this cycle |
| in_bit | input | 1 | Received serial bit |
| hold_search | input | 1 | Keeps the block in search |
| poly_taps | input | 31 | Feedback tap mask, bit i = delay i+1 |
| poly_order | input | 5 | Polynomial order n, 7..31 |
| los_clear | input | 1 | Write-one-to-clear for `los_flag` |
| locked | output | 1 | Current lock state |
| bit_err | output | 1 | One-cycle pulse per errored bit while locked |
| los_flag | output | 1 | Sticky loss-of-sync flag |

## Verification
A loss of sync and a software clear of the sticky flag can fall in the same cycle. The bench provokes this by driving `los_clear` high on the very valid bit that brings the window total to six. It judges the result by requiring `los_flag` to read 1, `locked` to read 0 and `bit_err` to read 1 in the following cycle. The window edge is also provoked from both sides: a sixth error 63 positions after the first must drop lock, and one 64 positions after must not.

// File: rtl/prbs_lock_pkg.sv
// Package: shared defaults and the sync state type of the pattern lock block.
// Assumes: the consumers take these values as parameter defaults only.
package prbs_lock_pkg;
    localparam int DEF_ORDER_MAX = 31;
    localparam int DEF_QUAL_BITS = 50;
    localparam int DEF_WIN_LEN   = 64;
    localparam int DEF_LOSS_ERRS = 6;

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } sync_state_e;
endpackage

// File: rtl/prbs_lock_lfsr.sv
// Module: local pattern generator. The shift register holds past bits, with
// bit 0 the newest. The prediction is the XOR of the tapped bits below the
// order. Assumes: 1 <= order <= ORDER_MAX.
module prbs_lock_lfsr #(
    parameter int ORDER_MAX = 31,
    parameter int ORDER_W   = $clog2(ORDER_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 take_rx,
    input  logic                 rx_bit,
    input  logic [ORDER_MAX-1:0] taps,
    input  logic [ORDER_W-1:0]   order,
    output logic                 pred
);
    logic [ORDER_MAX-1:0] sr_q;
    logic [ORDER_MAX-1:0] order_mask;
    logic                 feed;

    // Build the mask of register positions that belong to the polynomial.
    always_comb begin
        for (int i = 0; i < ORDER_MAX; i++) begin
            order_mask[i] = (i < int'(order));
        end
    end

    // Predict the next bit and pick what enters the register.
    always_comb begin
        pred = ^(sr_q & taps & order_mask);
        feed = take_rx ? rx_bit : pred;
    end

    // Shift on every accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[ORDER_MAX-2:0], feed};
        end
    end
endmodule

// File: rtl/prbs_lock_window.sv
// Module: sliding error-density window. It keeps WIN_LEN error flags and
// their running total, and flags when a new errored bit brings the total to
// LOSS_ERRS. Assumes: clr is raised in the same cycle as any hit.
module prbs_lock_window #(
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 6,
    parameter int CNTW      = $clog2(WIN_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            shift_en,
    input  logic            err_in,
    output logic            hit,
    output logic [CNTW-1:0] count
);
    logic [WIN_LEN-1:0] hist_q;
    logic [CNTW-1:0]    cnt_q;
    logic [CNTW:0]      cnt_sum;

    // New total with the incoming flag added and the oldest one retired.
    always_comb begin
        cnt_sum = {1'b0, cnt_q} + (CNTW + 1)'(err_in)
                - (CNTW + 1)'(hist_q[WIN_LEN-1]);
        hit     = shift_en && err_in && (cnt_sum >= (CNTW + 1)'(LOSS_ERRS));
        count   = cnt_q;
    end

    // Hold the history and the total, and empty both on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[WIN_LEN-2:0], err_in};
            cnt_q  <= cnt_sum[CNTW-1:0];
        end
    end
endmodule

// File: rtl/prbs_lock_fsm.sv
// Module: search and lock controller. It counts load and qualification bits
// in search, declares lock after order+QUAL_BITS clean bits and drops lock
// on a window hit. Assumes: hit is only raised for accepted bits while locked.
module prbs_lock_fsm
    import prbs_lock_pkg::*;
#(
    parameter int ORDER_MAX = 31,
    parameter int ORDER_W   = $clog2(ORDER_MAX + 1),
    parameter int QUAL_BITS = 50,
    parameter int CNTW      = $clog2(ORDER_MAX + QUAL_BITS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic               valid,
    input  logic               mismatch,
    input  logic [ORDER_W-1:0] order,
    input  logic               hit,
    output logic               locked
);
    sync_state_e     state_q;
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] load_end;
    logic [CNTW-1:0] qual_end;

    // Positions where loading ends and where qualification ends.
    always_comb begin
        load_end = CNTW'(order);
        qual_end = CNTW'(order) + CNTW'(QUAL_BITS - 1);
        locked   = (state_q == ST_LOCKED);
    end

    // Move between search and lock on accepted bits.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            state_q <= ST_SEARCH;
            cnt_q   <= '0;
        end else if (valid) begin
            if (state_q == ST_SEARCH) begin
                if (cnt_q < load_end) begin
                    cnt_q <= cnt_q + 1'b1;
                end else if (mismatch) begin
                    cnt_q <= '0;
                end else if (cnt_q == qual_end) begin
                    state_q <= ST_LOCKED;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (hit) begin
                state_q <= ST_SEARCH;
                cnt_q   <= '0;
            end
        end
    end
endmodule

// File: rtl/prbs_lock_top.sv
// Module: serial pattern lock and error monitor top. It joins the generator,
// window and controller, and registers the error pulse and the sticky flag.
// Assumes: poly_taps and poly_order change only while hold_search is high.
module prbs_lock_top
    import prbs_lock_pkg::*;
#(
    parameter int ORDER_MAX = DEF_ORDER_MAX,
    parameter int QUAL_BITS = DEF_QUAL_BITS,
    parameter int WIN_LEN   = DEF_WIN_LEN,
    parameter int LOSS_ERRS = DEF_LOSS_ERRS
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic                               in_bit,
    input  logic                               hold_search,
    input  logic [ORDER_MAX-1:0]               poly_taps,
    input  logic [$clog2(ORDER_MAX + 1)-1:0]   poly_order,
    input  logic                               los_clear,
    output logic                               locked,
    output logic                               bit_err,
    output logic                               los_flag
);
    localparam int ORDER_W  = $clog2(ORDER_MAX + 1);
    localparam int SRCH_W   = $clog2(ORDER_MAX + QUAL_BITS + 1);
    localparam int WIN_CNTW = $clog2(WIN_LEN + 1);

    logic                pred;
    logic                mismatch;
    logic                take;
    logic                err_now;
    logic                win_hit;
    logic                win_clr;
    logic [WIN_CNTW-1:0] win_count;
    logic                bit_err_q;
    logic                los_q;

    // Qualify the accepted bit and the error it carries.
    always_comb begin
        take     = in_valid && !hold_search;
        mismatch = in_bit ^ pred;
        err_now  = locked && take && mismatch;
        win_clr  = !locked || win_hit || hold_search;
    end

    prbs_lock_lfsr #(
        .ORDER_MAX (ORDER_MAX),
        .ORDER_W   (ORDER_W)
    ) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (take),
        .take_rx  (!locked),
        .rx_bit   (in_bit),
        .taps     (poly_taps),
        .order    (poly_order),
        .pred     (pred)
    );

    prbs_lock_window #(
        .WIN_LEN   (WIN_LEN),
        .LOSS_ERRS (LOSS_ERRS),
        .CNTW      (WIN_CNTW)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (win_clr),
        .shift_en (locked && take),
        .err_in   (err_now),
        .hit      (win_hit),
        .count    (win_count)
    );

    prbs_lock_fsm #(
        .ORDER_MAX (ORDER_MAX),
        .ORDER_W   (ORDER_W),
        .QUAL_BITS (QUAL_BITS),
        .CNTW      (SRCH_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold_search),
        .valid    (in_valid),
        .mismatch (mismatch),
        .order    (poly_order),
        .hit      (win_hit),
        .locked   (locked)
    );

    // Register the error pulse and the sticky loss flag (set beats clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_err_q <= 1'b0;
            los_q     <= 1'b0;
        end else begin
            bit_err_q <= err_now;
            if (win_hit) begin
                los_q <= 1'b1;
            end else if (los_clear) begin
                los_q <= 1'b0;
            end
        end
    end

    assign bit_err  = bit_err_q;
    assign los_flag = los_q;
endmodule

// File: rtl/prbs_lock_checker.sv
// Module: property checker for the pattern lock top, attached by bind.
// Assumes: win_count is the window total held in the top.
module prbs_lock_checker #(
    parameter int CNTW      = 7,
    parameter int LOSS_ERRS = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            hold_search,
    input logic            los_clear,
    input logic            locked,
    input logic            bit_err,
    input logic            los_flag,
    input logic [CNTW-1:0] win_count
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!locked && !bit_err && !los_flag));

    a_r4_err_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> $past(locked));

    a_r5_window_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        win_count < CNTW'(LOSS_ERRS));

    a_r6_los_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (los_flag && !los_clear) |=> los_flag);

    a_r6_los_set_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_flag) |-> ($past(locked) && !locked && bit_err));

    a_r7_hold_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        hold_search |=> !locked);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !hold_search) |=> (!bit_err && $stable(locked)));
endmodule

bind prbs_lock_top prbs_lock_checker #(
    .CNTW      (WIN_CNTW),
    .LOSS_ERRS (LOSS_ERRS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .hold_search (hold_search),
    .los_clear   (los_clear),
    .locked      (locked),
    .bit_err     (bit_err),
    .los_flag    (los_flag),
    .win_count   (win_count)
);

// File: tb/prbs_lock_top_tb_top.sv
// Bench: directed scenarios for the pattern lock top, one task each.
module prbs_lock_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_bit = 1'b0;
    logic        hold_search = 1'b0;
    logic [30:0] poly_taps = 31'h60;
    logic [4:0]  poly_order = 5'd7;
    logic        los_clear = 1'b0;
    logic        locked;
    logic        bit_err;
    logic        los_flag;

    logic [30:0] gen_q = 31'h7fff_ffff;
    logic [30:0] gen_mask = 31'h60;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    prbs_lock_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_bit      (in_bit),
        .hold_search (hold_search),
        .poly_taps   (poly_taps),
        .poly_order  (poly_order),
        .los_clear   (los_clear),
        .locked      (locked),
        .bit_err     (bit_err),
        .los_flag    (los_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic b, input logic v);
        in_valid = v;
        in_bit   = b;
        @(posedge clk);
        #1;
    endtask

    function automatic logic gen_bit();
        return ^(gen_q & gen_mask);
    endfunction

    task automatic send_gen(input logic flip);
        logic b;
        b = gen_bit();
        gen_q = {gen_q[29:0], b};
        step(b ^ flip, 1'b1);
    endtask

    task automatic send_clean(input int cnt);
        for (int i = 0; i < cnt; i++) send_gen(1'b0);
    endtask

    task automatic set_poly(input logic [30:0] m, input logic [4:0] o);
        poly_taps  = m;
        poly_order = o;
        gen_mask   = m;
    endtask

    task automatic do_reset(input logic [30:0] m, input logic [4:0] o);
        rst_n = 1'b0;
        set_poly(m, o);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        check(!locked && !bit_err && !los_flag, "R1 outputs after reset",
              {locked, bit_err, los_flag}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_lock_time(input logic [30:0] m, input logic [4:0] o, input string tag);
        do_reset(m, o);
        send_clean(int'(o) + 49);
        check(!locked, {tag, " no lock one bit early"}, locked, 0);
        send_gen(1'b0);
        check(locked, {tag, " lock after n+50 bits"}, locked, 1);
        check(!bit_err, "R4 no pulse at lock", bit_err, 0);
    endtask

    task automatic t_qual_error();
        do_reset(31'h60, 5'd7);
        send_clean(19);
        send_gen(1'b1);
        send_clean(7 + 49);
        check(!locked, "R3 restart after mismatch, not yet locked", locked, 0);
        send_gen(1'b0);
        check(locked, "R3 lock n+50 bits after mismatch", locked, 1);
    endtask

    task automatic t_locked_err();
        do_reset(31'h60, 5'd7);
        send_clean(57);
        send_gen(1'b1);
        check(bit_err, "R4 pulse on errored bit", bit_err, 1);
        check(locked, "R4 single error keeps lock", locked, 1);
        send_gen(1'b0);
        check(!bit_err, "R4 no pulse on clean bit", bit_err, 0);
        step(gen_bit() ^ 1'b1, 1'b0);
        check(!bit_err, "R8 invalid wrong bit gives no pulse", bit_err, 0);
        step(gen_bit() ^ 1'b1, 1'b0);
        check(locked, "R8 invalid bits keep lock", locked, 1);
        send_gen(1'b0);
        check(!bit_err && locked, "R8 generator not advanced by invalid bits",
              {bit_err, locked}, 1);
    endtask

    task automatic t_window_in();
        do_reset(31'h60, 5'd7);
        send_clean(57);
        for (int i = 0; i < 5; i++) send_gen(1'b1);
        check(locked, "R5 five errors keep lock", locked, 1);
        send_clean(58);
        send_gen(1'b1);
        check(!locked, "R5 six errors over 64 positions drop lock", locked, 0);
        check(los_flag, "R5 loss flag set", los_flag, 1);
        check(bit_err, "R5 pulse on the sixth error", bit_err, 1);
    endtask

    task automatic t_window_out();
        do_reset(31'h60, 5'd7);
        send_clean(57);
        for (int i = 0; i < 5; i++) send_gen(1'b1);
        send_clean(59);
        send_gen(1'b1);
        check(locked, "R5 six errors over 65 positions keep lock", locked, 1);
        check(!los_flag, "R5 no loss flag", los_flag, 0);
    endtask

    task automatic t_sticky();
        do_reset(31'h60, 5'd7);
        send_clean(57);
        for (int i = 0; i < 6; i++) send_gen(1'b1);
        check(!locked && los_flag, "R6 loss after six errors", {locked, los_flag}, 1);
        send_clean(57);
        check(locked, "R6 relock after loss", locked, 1);
        check(los_flag, "R6 flag stays through relock", los_flag, 1);
        los_clear = 1'b1;
        step(1'b0, 1'b0);
        los_clear = 1'b0;
        check(!los_flag, "R6 write-one clears flag", los_flag, 0);
        for (int i = 0; i < 5; i++) send_gen(1'b1);
        los_clear = 1'b1;
        send_gen(1'b1);
        los_clear = 1'b0;
        check(los_flag, "R6 set wins over clear", los_flag, 1);
        check(!locked && bit_err, "R6 loss in the clear cycle", {locked, bit_err}, 1);
    endtask

    task automatic t_hold();
        do_reset(31'h60, 5'd7);
        send_clean(57);
        check(locked, "R7 locked before hold", locked, 1);
        hold_search = 1'b1;
        send_clean(2);
        set_poly(31'h110, 5'd9);
        step(1'b0, 1'b0);
        check(!locked, "R7 hold forces search", locked, 0);
        check(!los_flag, "R7 hold leaves flag clear", los_flag, 0);
        hold_search = 1'b0;
        send_clean(9 + 49);
        check(!locked, "R7 new polynomial not locked early", locked, 0);
        send_gen(1'b0);
        check(locked, "R7 lock to new polynomial", locked, 1);
    endtask

    task automatic t_valid_gap();
        do_reset(31'h60, 5'd7);
        for (int i = 0; i < 56; i++) begin
            send_gen(1'b0);
            step(~gen_bit(), 1'b0);
        end
        check(!locked, "R8 gaps do not count toward lock", locked, 0);
        send_gen(1'b0);
        check(locked, "R8 lock after n+50 valid bits with gaps", locked, 1);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_lock_time(31'h60, 5'd7, "R2 order 7");
        t_lock_time(31'h6000, 5'd15, "R9 order 15");
        t_lock_time(31'h4800_0000, 5'd31, "R9 order 31");
        t_qual_error();
        t_locked_err();
        t_window_in();
        t_window_out();
        t_sticky();
        t_hold();
        t_valid_gap();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule